// File: doc/BRIEF.md
# Staggered RAS Refresh Sequencer

This block runs one refresh operation across a DRAM array of eight rows, each row selected by its own active-low RAS line. On a start request it walks the rows in a rotating order. The first row taken low is the one after the row that was active before the refresh. The order then climbs with wraparound, so the previously active row is taken low last. That row stays high for the longest time at the start of the sequence, which gives it its precharge. Each line is held low for a fixed number of host clocks. Lines go low one clock apart and come back high in the same order and with the same spacing, so at most one RAS edge happens in any cycle and the supply surge stays small.

Two refresh flavours are supported. In address-driven mode the refresh row address appears on the 12-bit multiplexed address bus while the sequence runs. In CAS-first mode the address bus stays at zero and a single CAS-enable output frames the RAS activity. The refresh can also run as a burst of one to four back-to-back passes, with the row address stepping by one after each pass. At the end all RAS lines are high, and a one-cycle completion pulse comes with a row-miss flag. The flag tells the memory controller that its next access must open a fresh row.

Top module: `ras_stagger_refresh`

## Requirements
- R1: Outside a refresh, including after reset, ras_n is 8'hFF, ma is 0, cas_en is 0, and done and row_miss are 0.
- R2: start is accepted when the block is idle. The first pass begins in the cycle after the accepting edge, and that cycle is step 0. Row r goes low at step 1+k, where k = (r - last_row - 1) mod 8, so rows are taken low one clock apart in ascending order from last_row+1.
- R3: Each RAS line stays low for exactly 8 consecutive cycles and then returns high. The lines return high in the order they went low, one clock apart, and a pass lasts 17 cycles (steps 0 to 16).
- R4: The row given by last_row stays high from step 0 through step 7 and is the last row taken low, at step 8.
- R5: With cbr_mode = 0, ma carries the captured ref_addr plus the pass index (modulo 4096) for every cycle of that pass. With cbr_mode = 1, or while idle, ma is 0.
- R6: With cbr_mode = 1, cas_en is 1 for every cycle of every pass. It rises one clock before the first RAS falls and falls one clock after the last RAS rises. With cbr_mode = 0, cas_en stays 0.
- R7: burst_len is captured at start and sets the number of passes to burst_len + 1 (1 to 4). The passes run back to back with no idle cycle between them.
- R8: In the cycle after step 16 of the final pass, done and row_miss are both 1 for exactly one cycle, with all RAS lines high.
- R9: A start that arrives during a refresh is ignored. The running sequence keeps its order, timing, mode, pass count and address.
- R10: At most one RAS line changes value between any two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Refresh request, taken when idle |
| cbr_mode | input | 1 | 1 = CAS-first refresh, 0 = address-driven refresh |
| burst_len | input | 2 | Number of passes minus one |
| last_row | input | 3 | Row whose RAS was active before the refresh |
| ref_addr | input | 12 | Refresh row address for the first pass |
| ras_n | output | 8 | Active-low row strobes, one per row |
| ma | output | 12 | Multiplexed memory address bus |
| cas_en | output | 1 | CAS enable during CAS-first refresh |
| done | output | 1 | One-cycle completion pulse |
| row_miss | output | 1 | Next access must treat its row as closed |

## Verification
The hardest case to reach is a second start request landing partway through a multi-pass burst, carrying a different mode, row, address and count. To reach it, the bench starts an address-driven burst of two passes and then, five cycles later while the RAS wave is moving, pulses start again with conflicting fields. The scoreboard expects the original trace unchanged, cycle for cycle. A second hard spot is the address wrapping past 4095 between burst passes. A four-pass CAS-first burst and an address-driven burst starting near the top of the address range cover it, together with rotations from last_row values 0, 3, 5 and 7.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  // Position of a row in the rotated activation order (0 = first low).
  function automatic int slot_of(input int row, input int last, input int rows);
    return (row + rows - last - 1) % rows;
  endfunction

  // True while step lies in [first, first+len).
  function automatic logic in_window(input int step, input int first, input int len);
    return (step >= first) && (step < first + len);
  endfunction

  // Cycles in one pass: lead step, stagger span, hold, closing all-high step.
  function automatic int pass_cycles(input int lead, input int rows, input int hold);
    return lead + (rows - 1) + hold + 1;
  endfunction
endpackage

// File: rtl/rsr_seq_ctrl.sv
module rsr_seq_ctrl #(
  parameter int PASS_LEN = 17,
  parameter int BURST_W  = 2,
  localparam int STEP_W  = $clog2(PASS_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [BURST_W-1:0] burst_len,
  output logic               busy,
  output logic [STEP_W-1:0]  step,
  output logic               pass_wrap,
  output logic               done
);
  logic [BURST_W-1:0] pass_q;
  logic [BURST_W-1:0] last_pass_q;
  logic               step_end;

  assign step_end  = busy && (step == STEP_W'(PASS_LEN - 1));
  assign pass_wrap = step_end && (pass_q != last_pass_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      step        <= '0;
      pass_q      <= '0;
      last_pass_q <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy        <= 1'b1;
        step        <= '0;
        pass_q      <= '0;
        last_pass_q <= burst_len;
      end else if (step_end) begin
        step <= '0;
        if (pass_wrap) begin
          pass_q <= pass_q + 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsr_ras_decode.sv
module rsr_ras_decode #(
  parameter int ROWS   = 8,
  parameter int HOLD   = 8,
  parameter int LEAD   = 1,
  parameter int STEP_W = 5,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic [ROW_W-1:0]  last_row,
  output logic [ROWS-1:0]   ras_n
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic low_now;
    assign low_now = busy && rsr_pkg::in_window(int'(step),
                     LEAD + rsr_pkg::slot_of(r, int'(last_row), ROWS), HOLD);
    assign ras_n[r] = ~low_now;
  end
endmodule

// File: rtl/rsr_addr_gen.sv
module rsr_addr_gen #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              pass_wrap,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (accept)    addr_q <= ref_addr;
    else if (pass_wrap) addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/ras_stagger_refresh.sv
module ras_stagger_refresh #(
  parameter int ROWS    = 8,
  parameter int ADDR_W  = 12,
  parameter int HOLD    = 8,
  parameter int BURST_W = 2,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int LEAD     = 1,
  localparam int PASS_LEN = rsr_pkg::pass_cycles(LEAD, ROWS, HOLD),
  localparam int STEP_W   = $clog2(PASS_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cbr_mode,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [ROW_W-1:0]   last_row,
  input  logic [ADDR_W-1:0]  ref_addr,
  output logic [ROWS-1:0]    ras_n,
  output logic [ADDR_W-1:0]  ma,
  output logic               cas_en,
  output logic               done,
  output logic               row_miss
);
  logic              busy;
  logic              accept;
  logic              pass_wrap;
  logic [STEP_W-1:0] step;
  logic [ROW_W-1:0]  last_row_q;
  logic              cbr_q;
  logic [ADDR_W-1:0] addr_q;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_row_q <= '0;
      cbr_q      <= 1'b0;
    end else if (accept) begin
      last_row_q <= last_row;
      cbr_q      <= cbr_mode;
    end
  end

  rsr_seq_ctrl #(.PASS_LEN(PASS_LEN), .BURST_W(BURST_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .burst_len(burst_len),
    .busy(busy), .step(step), .pass_wrap(pass_wrap), .done(done)
  );

  rsr_ras_decode #(.ROWS(ROWS), .HOLD(HOLD), .LEAD(LEAD), .STEP_W(STEP_W)) ras_i (
    .busy(busy), .step(step), .last_row(last_row_q), .ras_n(ras_n)
  );

  rsr_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pass_wrap(pass_wrap),
    .ref_addr(ref_addr), .addr_q(addr_q)
  );

  assign ma       = (busy && !cbr_q) ? addr_q : '0;
  assign cas_en   = busy && cbr_q;
  assign row_miss = done;
endmodule

// File: rtl/rsr_chk.sv
module rsr_chk #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ROWS-1:0]   ras_n,
  input logic [ADDR_W-1:0] ma,
  input logic              cas_en,
  input logic              done,
  input logic              row_miss
);
  // R10
  one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ras_n ^ $past(ras_n)) <= 1);
  // R1
  idle_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n == '1 && ma == '0 && !cas_en));
  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n == '1 && row_miss && !busy));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5
  cbr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_en |-> ma == '0);
endmodule

bind ras_stagger_refresh rsr_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ras_n(ras_n), .ma(ma),
  .cas_en(cas_en), .done(done), .row_miss(row_miss)
);

// File: tb/ras_stagger_refresh_tb_top.sv
module ras_stagger_refresh_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cbr_mode = 1'b0;
  logic [1:0]  burst_len = '0;
  logic [2:0]  last_row = '0;
  logic [11:0] ref_addr = '0;
  logic [7:0]  ras_n;
  logic [11:0] ma;
  logic        cas_en, done, row_miss;

  int checks = 0;
  int fails  = 0;
  logic [22:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ras_stagger_refresh dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cbr_mode(cbr_mode),
    .burst_len(burst_len), .last_row(last_row), .ref_addr(ref_addr),
    .ras_n(ras_n), .ma(ma), .cas_en(cas_en), .done(done), .row_miss(row_miss)
  );

  // Expected vector layout: {ras_n, ma, cas_en, done, row_miss}
  function automatic logic [7:0] ras_at(input int s, input int last);
    logic [7:0] v = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      int row = (last + 1 + k) % 8;
      if (s >= k + 1 && s <= k + 8) v[row] = 1'b0;
    end
    return v;
  endfunction

  task automatic run_refresh(input logic cbr, input int last, input logic [11:0] addr,
                             input int passes, input bit poke, input string tag);
    @(negedge clk);
    cbr_mode = cbr; last_row = 3'(last); ref_addr = addr; burst_len = 2'(passes - 1);
    start = 1'b1;
    for (int p = 0; p < passes; p++) begin
      for (int s = 0; s < 17; s++) begin
        logic [11:0] a = cbr ? 12'h000 : 12'(addr + 12'(p));
        exp_q.push_back({ras_at(s, last), a, cbr, 1'b0, 1'b0});
        tag_q.push_back(tag);
      end
    end
    exp_q.push_back({8'hFF, 12'h000, 1'b0, 1'b1, 1'b1}); tag_q.push_back("R8");
    exp_q.push_back({8'hFF, 12'h000, 1'b0, 1'b0, 1'b0}); tag_q.push_back("R1");
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      cbr_mode = ~cbr; last_row = 3'(last + 4); ref_addr = ~addr; burst_len = 2'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [22:0] e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {ras_n, ma, cas_en, done, row_miss};
        checks++;
        if (g !== e) begin
          fails++;
          $display("FAIL %s got ras=%h ma=%h cas=%b done=%b miss=%b exp ras=%h ma=%h cas=%b done=%b miss=%b",
                   t, g[22:15], g[14:3], g[2], g[1], g[0], e[22:15], e[14:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({ras_n, ma, cas_en, done, row_miss} !== {8'hFF, 12'h000, 3'b000}) begin
      fails++;
      $display("FAIL R1 reset got ras=%h ma=%h cas=%b done=%b exp ras=ff ma=000 cas=0 done=0",
               ras_n, ma, cas_en, done);
    end
    // R2 R3 R4 R5: single address-driven pass from row 0
    run_refresh(1'b0, 0, 12'h123, 1, 1'b0, "R2 R3 R4 R5");
    // R6 R7: four-pass CAS-first burst, last row 7
    run_refresh(1'b1, 7, 12'hABC, 4, 1'b0, "R6 R7");
    // R9: start during a two-pass address-driven burst is ignored
    run_refresh(1'b0, 3, 12'h0F0, 2, 1'b1, "R9");
    // R5 R7: address wraps between passes
    run_refresh(1'b0, 5, 12'hFFE, 3, 1'b0, "R5 R7");
    // R4 R6: single CAS-first pass, last row 5
    run_refresh(1'b1, 5, 12'h555, 1, 1'b0, "R4 R6");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule